// File: doc/BRIEF.md
# Shared Bit-Scan and Bit-Count Execution Unit

This execution unit computes five bit-oriented operations on a 64-bit or 32-bit source value: leading-zero count, trailing-zero count, population count, lowest-set-bit scan and highest-set-bit scan. All five share one datapath. The two scans leave the destination unchanged when the source is zero, so the unit also takes the previous destination value as an input.

Besides the result, the unit returns a zero flag for the source and a carry-style flag for the zero-count operations. It also returns a dependency flag, which is high only when the previous destination value was actually passed through to the result. A scheduler can use this flag to stop treating the old destination as an input of the count operations.

Each operation takes one cycle. The result sits in a single output register with a valid/ready handshake.

Top module: `bsu_scan_count_unit`

## Requirements
- R1: Operation codes on `in_op` are 0 leading-zero count, 1 trailing-zero count, 2 population count, 3 lowest-set-bit scan and 4 highest-set-bit scan. Codes 5 to 7 give a result of 0 with `out_zf`, `out_cf` and `out_old_used` all low.
- R2: Leading-zero count returns the number of zero bits above the highest set bit within the selected width. It returns the width (32 or 64) when the source is zero.
- R3: Trailing-zero count returns the number of zero bits below the lowest set bit. It returns the width (32 or 64) when the source is zero.
- R4: Population count returns the number of set bits within the selected width. An all-ones source gives 64 in wide mode and 32 in narrow mode.
- R5: For a nonzero source, the lowest-set-bit scan returns the index of the lowest set bit. The highest-set-bit scan returns the index of the highest set bit, which equals width-1 minus the leading-zero count.
- R6: For a zero source, both scans return all 64 bits of `in_old` unchanged and raise `out_old_used`.
- R7: `out_old_used` is 0 for the three count operations whatever the source is, and 0 for the scans when the source is nonzero.
- R8: With `in_rep` high, code 3 executes exactly as a trailing-zero count, including its zero-source result, its flags and `out_old_used`=0. `in_rep` has no effect on the other codes.
- R9: With `in_wide` low, source bits 63:32 are ignored and result bits 63:32 are zero. The only exception is the zero-source scan case of R6.
- R10: For codes 0 to 4, `out_zf` is 1 exactly when the source within the selected width is zero. `out_cf` equals `out_zf` for the leading-zero and trailing-zero counts and is 0 for every other operation.
- R11: `in_ready` is high when the output register is empty or is being drained. An input accepted on an edge makes `out_valid` high from the next cycle on. The output stays unchanged while `out_valid` is high and `out_ready` is low.
- R12: Synchronous active-high reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 3 | Operation code |
| in_rep | input | 1 | Repeat-style prefix; turns code 3 into trailing-zero count |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| in_src | input | 64 | Source value |
| in_old | input | 64 | Previous destination value |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Destination value |
| out_zf | output | 1 | Source was zero |
| out_cf | output | 1 | Zero source on a zero-count operation |
| out_old_used | output | 1 | Previous destination value was passed to the result |

## Verification
A wrong internal state shows up at the ports within one cycle of the accepted operation, because each result depends only on the operation accepted on the edge before it. A miscounting priority chain gives a wrong count or index. An error of this kind hides unless the stimulus puts the deciding bit at a boundary, such as bit 0, bit 31, bit 32 or bit 63, or uses an all-zero or all-ones source. A wrong handshake register shows as a result that is lost, duplicated or changed while back-pressure is held. This appears as a mismatch on the very next comparison against the queued expectation.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int FULL_W = 64;
    localparam int HALF_W = 32;
    localparam int CNT_W  = $clog2(FULL_W + 1);
    localparam int IDX_W  = $clog2(FULL_W);

    typedef enum logic [2:0] {
        OP_LZC   = 3'd0,
        OP_TZC   = 3'd1,
        OP_POP   = 3'd2,
        OP_FSCAN = 3'd3,
        OP_RSCAN = 3'd4
    } bsu_op_e;

    typedef struct packed {
        logic [FULL_W-1:0] value;
        logic              zf;
        logic              cf;
        logic              old_used;
    } bsu_res_t;

    // The repeat prefix turns a lowest-set-bit scan into a trailing count.
    function automatic logic [2:0] resolve_op(input logic [2:0] op, input logic rep);
        if (rep && op == OP_FSCAN)
            return OP_TZC;
        return op;
    endfunction

    function automatic logic is_scan(input logic [2:0] op);
        return (op == OP_FSCAN) || (op == OP_RSCAN);
    endfunction
endpackage

// File: rtl/bsu_lead_zero.sv
module bsu_lead_zero #(
    parameter int W  = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // The last set bit found scanning upwards is the highest one.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i])
                count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/bsu_pop_count.sv
module bsu_pop_count #(
    parameter int W  = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++)
            count = count + CW'(vec[i]);
    end
endmodule

// File: rtl/bsu_out_stage.sv
module bsu_out_stage
    import bsu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  bsu_res_t nxt,
    input  logic     drain,
    output logic     busy,
    output bsu_res_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            cur  <= nxt;
        end else if (drain) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/bsu_scan_count_unit.sv
module bsu_scan_count_unit
    import bsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic              in_rep,
    input  logic              in_wide,
    input  logic [FULL_W-1:0] in_src,
    input  logic [FULL_W-1:0] in_old,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FULL_W-1:0] out_result,
    output logic              out_zf,
    output logic              out_cf,
    output logic              out_old_used
);
    logic [FULL_W-1:0] src_m;
    logic [FULL_W-1:0] src_rev;
    logic [CNT_W-1:0]  lz_full;
    logic [CNT_W-1:0]  tz_full;
    logic [CNT_W-1:0]  ones;
    logic [CNT_W-1:0]  width_cnt;
    logic [CNT_W-1:0]  lzc;
    logic [CNT_W-1:0]  tzc;
    logic [IDX_W-1:0]  idx_lo;
    logic [IDX_W-1:0]  idx_hi;
    logic              src_zero;
    logic [2:0]        eff_op;
    logic              take;
    logic              busy;
    bsu_res_t          nxt;
    bsu_res_t          cur;

    // Narrow mode clears the upper half so one full-width datapath serves both.
    assign src_m = in_wide ? in_src : {{(FULL_W-HALF_W){1'b0}}, in_src[HALF_W-1:0]};

    generate
        for (genvar g = 0; g < FULL_W; g++) begin : g_rev
            assign src_rev[g] = src_m[FULL_W-1-g];
        end
    endgenerate

    bsu_lead_zero #(.W(FULL_W)) u_lead (.vec(src_m),   .count(lz_full));
    bsu_lead_zero #(.W(FULL_W)) u_trail(.vec(src_rev), .count(tz_full));
    bsu_pop_count #(.W(FULL_W)) u_pop  (.vec(src_m),   .count(ones));

    assign src_zero  = (src_m == '0);
    assign width_cnt = in_wide ? CNT_W'(FULL_W) : CNT_W'(HALF_W);
    assign lzc       = in_wide ? lz_full : lz_full - CNT_W'(FULL_W - HALF_W);
    assign tzc       = src_zero ? width_cnt : tz_full;
    assign idx_lo    = tz_full[IDX_W-1:0];
    assign idx_hi    = IDX_W'(CNT_W'(FULL_W - 1) - lz_full);
    assign eff_op    = resolve_op(in_op, in_rep);

    always_comb begin
        nxt = '0;
        case (eff_op)
            OP_LZC: begin
                nxt.value = FULL_W'(lzc);
                nxt.zf    = src_zero;
                nxt.cf    = src_zero;
            end
            OP_TZC: begin
                nxt.value = FULL_W'(tzc);
                nxt.zf    = src_zero;
                nxt.cf    = src_zero;
            end
            OP_POP: begin
                nxt.value = FULL_W'(ones);
                nxt.zf    = src_zero;
            end
            OP_FSCAN, OP_RSCAN: begin
                nxt.zf       = src_zero;
                nxt.old_used = src_zero;
                if (src_zero)
                    nxt.value = in_old;
                else if (eff_op == OP_FSCAN)
                    nxt.value = FULL_W'(idx_lo);
                else
                    nxt.value = FULL_W'(idx_hi);
            end
            default: nxt = '0;
        endcase
        if (!is_scan(eff_op))
            nxt.old_used = 1'b0;
    end

    assign in_ready = !busy || out_ready;
    assign take     = in_valid && in_ready;

    bsu_out_stage u_stage (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .nxt  (nxt),
        .drain(out_ready),
        .busy (busy),
        .cur  (cur)
    );

    assign out_valid    = busy;
    assign out_result   = cur.value;
    assign out_zf       = cur.zf;
    assign out_cf       = cur.cf;
    assign out_old_used = cur.old_used;
endmodule

// File: rtl/bsu_chk.sv
module bsu_chk
    import bsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        in_op,
    input logic              in_rep,
    input logic              in_wide,
    input logic [FULL_W-1:0] in_src,
    input logic [FULL_W-1:0] in_old,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FULL_W-1:0] out_result,
    input logic              out_zf,
    input logic              out_cf,
    input logic              out_old_used
);
    logic accept;
    logic count_op;
    assign accept   = in_valid && in_ready;
    assign count_op = (in_op == OP_LZC) || (in_op == OP_TZC) || (in_op == OP_POP);

    // R11
    accept_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // R11
    empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R11
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_zf)
                                       && $stable(out_cf) && $stable(out_old_used)));

    // R7
    count_no_dep_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && count_op) |=> !out_old_used);

    // R6
    dep_only_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_old_used) |-> out_zf);

    // R10
    carry_implies_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cf) |-> out_zf);

    // R9
    narrow_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !in_wide && count_op) |=> (out_result[FULL_W-1:HALF_W] == '0));

    // R12
    reset_clears_valid_chk: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind bsu_scan_count_unit bsu_chk u_chk (.*);

// File: tb/bsu_scan_count_unit_test.sv
module bsu_scan_count_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic        in_rep = 1'b0;
    logic        in_wide = 1'b1;
    logic [63:0] in_src = '0;
    logic [63:0] in_old = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    logic        out_zf;
    logic        out_cf;
    logic        out_old_used;

    int total = 0;
    int bad = 0;
    logic took = 1'b0;
    bit   rand_ready = 1'b0;
    logic [66:0] expq[$];
    string       tagq[$];

    always #10 clk = ~clk;

    bsu_scan_count_unit uut (.*);

    // Behavioural model: {result, zf, cf, used}
    function automatic logic [66:0] model(input logic [2:0] op, input logic rep, input logic wide,
                                          input logic [63:0] src, input logic [63:0] old);
        int w;
        int n;
        bit found;
        logic [63:0] s;
        logic [63:0] r;
        logic z;
        logic c;
        logic u;
        w = wide ? 64 : 32;
        s = wide ? src : {32'h0, src[31:0]};
        z = (s == 64'h0);
        c = 1'b0;
        u = 1'b0;
        r = '0;
        if (op == 3'd3 && rep) op = 3'd1;
        n = 0;
        found = 0;
        case (op)
            3'd0: begin
                for (int i = w - 1; i >= 0; i--) if (!found) begin if (s[i]) found = 1; else n++; end
                r = 64'(n); c = z;
            end
            3'd1: begin
                for (int i = 0; i < w; i++) if (!found) begin if (s[i]) found = 1; else n++; end
                r = 64'(n); c = z;
            end
            3'd2: begin
                for (int i = 0; i < w; i++) n += int'(s[i]);
                r = 64'(n);
            end
            3'd3: begin
                if (z) begin r = old; u = 1'b1; end
                else begin
                    for (int i = 0; i < w; i++) if (!found && s[i]) begin found = 1; n = i; end
                    r = 64'(n);
                end
            end
            3'd4: begin
                if (z) begin r = old; u = 1'b1; end
                else begin
                    for (int i = w - 1; i >= 0; i--) if (!found && s[i]) begin found = 1; n = i; end
                    r = 64'(n);
                end
            end
            default: begin r = '0; z = 1'b0; end
        endcase
        return {r, z, c, u};
    endfunction

    // Samples 2 ns before each rising edge: compare first, then queue.
    always @(negedge clk) begin
        #8;
        took = 1'b0;
        if (!rst) begin
            if (out_valid && out_ready) begin
                logic [66:0] e;
                string t;
                total++;
                if (expq.size() == 0) begin
                    bad++;
                    $display("FAIL R11: unexpected output %h (expected none)", out_result);
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if ({out_result, out_zf, out_cf, out_old_used} !== e) begin
                        bad++;
                        $display("FAIL %s: actual res=%h zf=%b cf=%b used=%b expected res=%h zf=%b cf=%b used=%b",
                                 t, out_result, out_zf, out_cf, out_old_used,
                                 e[66:3], e[2], e[1], e[0]);
                    end
                end
            end
            if (in_valid && in_ready) begin
                took = 1'b1;
                expq.push_back(model(in_op, in_rep, in_wide, in_src, in_old));
                tagq.push_back(req_tag(in_op, in_rep, in_wide, in_src));
            end
        end
    end

    function automatic string req_tag(input logic [2:0] op, input logic rep, input logic wide,
                                      input logic [63:0] src);
        logic z;
        z = wide ? (src == 0) : (src[31:0] == 0);
        if (op == 3'd3 && rep) return "R8";
        if (op > 3'd4) return "R1";
        if (!wide && src[63:32] != 0) return "R9";
        if ((op == 3'd3 || op == 3'd4) && z) return "R6";
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic send(input logic [2:0] op, input logic rep, input logic wide,
                        input logic [63:0] src, input logic [63:0] old);
        @(negedge clk);
        #1;
        in_valid = 1'b1;
        in_op = op;
        in_rep = rep;
        in_wide = wide;
        in_src = src;
        in_old = old;
        do begin
            if (rand_ready) out_ready = ($urandom_range(0, 9) < 7);
            @(negedge clk);
            #1;
        end while (!took);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
            if (rand_ready) out_ready = ($urandom_range(0, 9) < 7);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] o;
        o = 64'hDEAD_BEEF_CAFE_F00D;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12: reset state
        total++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            bad++;
            $display("FAIL R12: actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
        end
        // R2 R3 R4 zero and full sources, both widths
        for (int op = 0; op < 5; op++) begin
            send(3'(op), 1'b0, 1'b1, 64'h0, o);
            send(3'(op), 1'b0, 1'b0, 64'h0, o);
            send(3'(op), 1'b0, 1'b1, '1, o);
            send(3'(op), 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF, o);
        end
        // R5 boundary bits
        for (int op = 0; op < 5; op++) begin
            send(3'(op), 1'b0, 1'b1, 64'h1, o);
            send(3'(op), 1'b0, 1'b1, 64'h8000_0000_0000_0000, o);
            send(3'(op), 1'b0, 1'b1, 64'h0000_0001_0000_0000, o);
            send(3'(op), 1'b0, 1'b0, 64'h0000_0000_8000_0000, o);
            send(3'(op), 1'b0, 1'b1, 64'h0000_0000_8000_0000, o);
        end
        // R9 upper half ignored in narrow mode
        for (int op = 0; op < 5; op++) begin
            send(3'(op), 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0000, o);
            send(3'(op), 1'b0, 1'b0, 64'hA5A5_A5A5_0001_0100, o);
        end
        // R8 prefix
        send(3'd3, 1'b1, 1'b1, 64'h0, o);
        send(3'd3, 1'b1, 1'b0, 64'h0, o);
        send(3'd3, 1'b1, 1'b1, 64'h0000_0100_0000_0000, o);
        send(3'd4, 1'b1, 1'b1, 64'h0, o);
        send(3'd0, 1'b1, 1'b0, 64'h10, o);
        // R1 unused codes
        for (int op = 5; op < 8; op++) send(3'(op), 1'b0, 1'b1, 64'h0, o);
        // R11 back-pressure with random traffic
        rand_ready = 1'b1;
        for (int k = 0; k < 400; k++) begin
            logic [63:0] s;
            s = {$urandom(), $urandom()};
            case ($urandom_range(0, 3))
                0: s = s & {$urandom(), $urandom()} & {$urandom(), $urandom()};
                1: s = 64'h1 << $urandom_range(0, 63);
                2: s = '0;
                default: ;
            endcase
            send(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 s, {$urandom(), $urandom()});
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        rand_ready = 1'b0;
        out_ready = 1'b1;
        idle(4);
        // R11: every accepted operation came out
        total++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL R11: actual pending=%0d expected pending=0", expq.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule